// File: doc/BRIEF.md
# Tenant-Partitioned Ternary Match Table

This block is a small ternary match table shared by several virtual tenants. A requester presents an opaque 112-bit key together with an 8-bit tenant identifier. The block extends the key with that identifier and compares it against every entry in parallel. Each entry holds a stored key, a per-bit care mask, the tenant identifier that owns it, a valid flag and a result word. Because the tenant identifier always takes part in the compare, every tenant sees only its own entries, even though all tenants share one physical table.

When several entries match, the entry at the lowest index wins. The block returns a hit flag, the winning index and that entry's result word one cycle after the request. The result word is opaque to the block. Software packs fields such as a physical queue number, an output tag and a counter index into it. A miss returns a cleared hit flag so that the requester can send the packet to a control processor instead.

A management port installs or invalidates one entry per cycle, chosen by index. A lookup that starts in the same cycle as a write sees the table as it was before that write.

Top module: `slice_tcam_lookup`

## Requirements
- R1: After reset every entry is invalid and the response outputs (rspValid, rspHit, rspIndex, rspResult) are all zero, so any lookup misses.
- R2: rspValid is high in exactly the cycle after a cycle in which lookupReq was high, and low otherwise (fixed latency of one).
- R3: An entry matches when it is valid, its tenant id equals lookupSlice, and lookupKey equals the stored key at every bit position where the stored mask bit is 1. Mask bits of 0 are don't-care.
- R4: The tenant id is always compared in full and is never masked. A key that matches an entry of another tenant misses.
- R5: When several entries match, rspIndex and rspResult come from the lowest-indexed matching entry.
- R6: On a miss, rspHit is 0 and rspIndex and rspResult are both 0.
- R7: When wrEn is high, wrValid=1 installs wrKey, wrMask, wrSlice and wrResult at entry wrIndex and marks it valid; wrValid=0 marks it invalid. The change is seen by lookups starting in the next cycle.
- R8: A lookup in the same cycle as a write to any entry, including the entry it would match, uses the contents from before that write.
- R9: In cycles after no request, rspHit, rspIndex and rspResult keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupReq | input | 1 | Lookup request strobe |
| lookupKey | input | 112 | Opaque search key |
| lookupSlice | input | 8 | Tenant identifier of the requester |
| rspValid | output | 1 | Response valid, one cycle after lookupReq |
| rspHit | output | 1 | At least one entry matched |
| rspIndex | output | 4 | Index of the winning entry (0 on miss) |
| rspResult | output | 32 | Result word of the winning entry (0 on miss) |
| wrEn | input | 1 | Management write strobe |
| wrIndex | input | 4 | Entry to write |
| wrValid | input | 1 | 1 installs the entry, 0 invalidates it |
| wrKey | input | 112 | Stored key value |
| wrMask | input | 112 | Care mask, 1 means the bit is compared |
| wrSlice | input | 8 | Owning tenant identifier |
| wrResult | input | 32 | Result word to store |

## Verification
The bench targets overlapping entries, where a design that encodes priority from the top would report the higher index. It also targets the same key installed under two tenants, where leaking the tenant field into the mask would give a cross-tenant hit. It stresses writes that land in the same cycle as a lookup on the same entry. A design that forwards the write would report the new result or a miss one cycle too early, and one that delays it would miss on the following lookup. Idle cycles after a hit catch outputs that clear or change without a request, and a random phase mixes installs, invalidations and lookups across three tenants against a behavioural table.

// File: rtl/stcam_pkg.sv
package stcam_pkg;
  // Strobes from the control module to the datapath
  typedef struct packed {
    logic lookupFire;    // a lookup is evaluated this cycle
    logic writeFire;     // a management write lands at this edge
    logic writeInstall;  // 1: install entry, 0: invalidate entry
  } stcam_strobe_t;
endpackage

// File: rtl/stcam_ctrl.sv
module stcam_ctrl
  import stcam_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          lookupReq,
  input  logic          wrEn,
  input  logic          wrValid,
  output stcam_strobe_t strobes,
  output logic          rspValid
);

  always_comb begin
    strobes.lookupFire   = lookupReq;
    strobes.writeFire    = wrEn;
    strobes.writeInstall = wrValid;
  end

  // Response valid follows the request by exactly one cycle
  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= lookupReq;
  end

  assert_latency_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    lookupReq |=> rspValid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !lookupReq |=> !rspValid);

endmodule

// File: rtl/stcam_datapath.sv
module stcam_datapath
  import stcam_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,  // power of two
  parameter int KEY_W       = 112,
  parameter int SLICE_W     = 8,
  parameter int RES_W       = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  stcam_strobe_t      strobes,
  input  logic               rspValid,
  input  logic [KEY_W-1:0]   lookupKey,
  input  logic [SLICE_W-1:0] lookupSlice,
  input  logic [IDX_W-1:0]   wrIndex,
  input  logic [KEY_W-1:0]   wrKey,
  input  logic [KEY_W-1:0]   wrMask,
  input  logic [SLICE_W-1:0] wrSlice,
  input  logic [RES_W-1:0]   wrResult,
  output logic               rspHit,
  output logic [IDX_W-1:0]   rspIndex,
  output logic [RES_W-1:0]   rspResult
);

  // Entry storage
  logic [NUM_ENTRIES-1:0] entryValid;
  logic [KEY_W-1:0]       entryKey    [NUM_ENTRIES];
  logic [KEY_W-1:0]       entryMask   [NUM_ENTRIES];
  logic [SLICE_W-1:0]     entrySlice  [NUM_ENTRIES];
  logic [RES_W-1:0]       entryResult [NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] matchVec;
  logic [NUM_ENTRIES-1:0] grantVec;
  logic [NUM_ENTRIES:0]   seenBelow;

  assign seenBelow[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NUM_ENTRIES; g++) begin : gEntry
      logic selThis;
      assign selThis = strobes.writeFire && (wrIndex == IDX_W'(g));

      always_ff @(posedge clk) begin
        if (!rstN)        entryValid[g] <= 1'b0;
        else if (selThis) entryValid[g] <= strobes.writeInstall;
      end

      always_ff @(posedge clk) begin
        if (selThis && strobes.writeInstall) begin
          entryKey[g]    <= wrKey;
          entryMask[g]   <= wrMask;
          entrySlice[g]  <= wrSlice;
          entryResult[g] <= wrResult;
        end
      end

      // Tenant id is compared unmasked; key bits only where mask is 1
      assign matchVec[g] = entryValid[g]
                        && (entrySlice[g] == lookupSlice)
                        && (((lookupKey ^ entryKey[g]) & entryMask[g]) == '0);

      // Lowest index wins
      assign seenBelow[g+1] = seenBelow[g] | matchVec[g];
      assign grantVec[g]    = matchVec[g] & ~seenBelow[g];
    end
  endgenerate

  logic             anyHit;
  logic [IDX_W-1:0] winIdx;
  logic [RES_W-1:0] winResult;

  always_comb begin
    anyHit    = |grantVec;
    winIdx    = '0;
    winResult = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (grantVec[i]) begin
        winIdx    = winIdx | IDX_W'(i);
        winResult = winResult | entryResult[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHit    <= 1'b0;
      rspIndex  <= '0;
      rspResult <= '0;
    end else if (strobes.lookupFire) begin
      rspHit    <= anyHit;
      rspIndex  <= winIdx;
      rspResult <= winResult;
    end
  end

  assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));

  assert_miss_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspResult == '0 && rspIndex == '0));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.lookupFire |=> ($stable(rspHit) && $stable(rspIndex) && $stable(rspResult)));

  assert_match_reports_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.lookupFire && (matchVec != '0)) |=> rspHit);

endmodule

// File: rtl/slice_tcam_lookup.sv
module slice_tcam_lookup
  import stcam_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int KEY_W       = 112,
  parameter int SLICE_W     = 8,
  parameter int RES_W       = 32,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupReq,
  input  logic [KEY_W-1:0]   lookupKey,
  input  logic [SLICE_W-1:0] lookupSlice,
  output logic               rspValid,
  output logic               rspHit,
  output logic [IDX_W-1:0]   rspIndex,
  output logic [RES_W-1:0]   rspResult,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIndex,
  input  logic               wrValid,
  input  logic [KEY_W-1:0]   wrKey,
  input  logic [KEY_W-1:0]   wrMask,
  input  logic [SLICE_W-1:0] wrSlice,
  input  logic [RES_W-1:0]   wrResult
);

  stcam_strobe_t strobes;

  stcam_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lookupReq(lookupReq),
    .wrEn     (wrEn),
    .wrValid  (wrValid),
    .strobes  (strobes),
    .rspValid (rspValid)
  );

  stcam_datapath #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .KEY_W      (KEY_W),
    .SLICE_W    (SLICE_W),
    .RES_W      (RES_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rspValid   (rspValid),
    .lookupKey  (lookupKey),
    .lookupSlice(lookupSlice),
    .wrIndex    (wrIndex),
    .wrKey      (wrKey),
    .wrMask     (wrMask),
    .wrSlice    (wrSlice),
    .wrResult   (wrResult),
    .rspHit     (rspHit),
    .rspIndex   (rspIndex),
    .rspResult  (rspResult)
  );

endmodule

// File: tb/test_slice_tcam_lookup.sv
module test_slice_tcam_lookup;

  localparam int N  = 16;
  localparam int KW = 112;
  localparam int SW = 8;
  localparam int RW = 32;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lookupReq = 1'b0;
  logic [KW-1:0] lookupKey = '0;
  logic [SW-1:0] lookupSlice = '0;
  logic          rspValid, rspHit;
  logic [IW-1:0] rspIndex;
  logic [RW-1:0] rspResult;
  logic          wrEn = 1'b0;
  logic [IW-1:0] wrIndex = '0;
  logic          wrValid = 1'b0;
  logic [KW-1:0] wrKey = '0;
  logic [KW-1:0] wrMask = '0;
  logic [SW-1:0] wrSlice = '0;
  logic [RW-1:0] wrResult = '0;

  always #2.5 clk = ~clk;  // 200 MHz

  slice_tcam_lookup i_slice_tcam_lookup (
    .clk(clk), .rstN(rstN),
    .lookupReq(lookupReq), .lookupKey(lookupKey), .lookupSlice(lookupSlice),
    .rspValid(rspValid), .rspHit(rspHit), .rspIndex(rspIndex), .rspResult(rspResult),
    .wrEn(wrEn), .wrIndex(wrIndex), .wrValid(wrValid), .wrKey(wrKey),
    .wrMask(wrMask), .wrSlice(wrSlice), .wrResult(wrResult)
  );

  // Behavioural table
  bit            mValid [N];
  logic [KW-1:0] mKey   [N];
  logic [KW-1:0] mMask  [N];
  logic [SW-1:0] mSlice [N];
  logic [RW-1:0] mRes   [N];

  // Expected held outputs
  bit            eHit = 0;
  int            eIdx = 0;
  logic [RW-1:0] eRes = '0;

  int compared = 0;
  int mismatched = 0;

  localparam logic [KW-1:0] KA = {32'hA5A5_0001, 80'h0};
  localparam logic [KW-1:0] KB = {32'h0BAD_F00D, 64'h0, 16'h1234};
  localparam logic [KW-1:0] FULL = '1;
  localparam logic [KW-1:0] LOW16DC = {{(KW-16){1'b1}}, 16'h0};

  function automatic void refLookup(input logic [KW-1:0] k, input logic [SW-1:0] s,
                                    output bit h, output int idx, output logic [RW-1:0] r);
    h = 0; idx = 0; r = '0;
    for (int i = 0; i < N; i++) begin
      if (!h && mValid[i] && mSlice[i] == s && ((k ^ mKey[i]) & mMask[i]) == '0) begin
        h = 1; idx = i; r = mRes[i];
      end
    end
  endfunction

  task automatic compare(input bit expV, input string tag);
    compared++;
    if (rspValid !== expV || rspHit !== eHit || rspIndex !== IW'(eIdx) || rspResult !== eRes) begin
      mismatched++;
      $display("FAIL %s: actual v=%0b hit=%0b idx=%0d res=%h expected v=%0b hit=%0b idx=%0d res=%h",
               tag, rspValid, rspHit, rspIndex, rspResult, expV, eHit, eIdx, eRes);
    end
  endtask

  // One clock: drive at negedge, evaluate against old table, update table at edge
  task automatic step(input bit req, input logic [KW-1:0] k, input logic [SW-1:0] s,
                      input bit we, input int widx, input bit wv,
                      input logic [KW-1:0] wk, input logic [KW-1:0] wm,
                      input logic [SW-1:0] ws, input logic [RW-1:0] wr, input string tag);
    lookupReq = req; lookupKey = k; lookupSlice = s;
    wrEn = we; wrIndex = IW'(widx); wrValid = wv; wrKey = wk; wrMask = wm;
    wrSlice = ws; wrResult = wr;
    if (req) refLookup(k, s, eHit, eIdx, eRes);
    @(posedge clk);
    if (we) begin
      mValid[widx] = wv;
      if (wv) begin
        mKey[widx] = wk; mMask[widx] = wm; mSlice[widx] = ws; mRes[widx] = wr;
      end
    end
    @(negedge clk);
    lookupReq = 1'b0; wrEn = 1'b0;
    compare(req, tag);
  endtask

  task automatic look(input logic [KW-1:0] k, input logic [SW-1:0] s, input string tag);
    step(1, k, s, 0, 0, 0, '0, '0, '0, '0, tag);
  endtask

  task automatic put(input int idx, input logic [KW-1:0] k, input logic [KW-1:0] m,
                     input logic [SW-1:0] s, input logic [RW-1:0] r, input string tag);
    step(0, '0, '0, 1, idx, 1, k, m, s, r, tag);
  endtask

  task automatic idle(input string tag);
    step(0, '0, '0, 0, 0, 0, '0, '0, '0, '0, tag);
  endtask

  initial begin
    #(5 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mValid[i] = 0; mKey[i] = '0; mMask[i] = '0; mSlice[i] = '0; mRes[i] = '0;
    end
    repeat (3) @(negedge clk);
    compare(0, "R1 reset outputs");
    rstN = 1'b1;
    @(negedge clk);

    look(KA, 8'd5, "R1 empty table misses");
    put(3, KA, FULL, 8'd5, 32'hAAAA_0003, "R7 install");
    look(KA, 8'd5, "R7 R3 exact hit");
    look(KA, 8'd6, "R4 other tenant misses");
    look(KA ^ (KW'(1) << 100), 8'd5, "R3 cared bit differs");
    look('0, 8'd0, "R6 miss clears");

    // Don't-care bits and overlap priority
    put(7, KB, LOW16DC, 8'd5, 32'hBBBB_0007, "R7 install masked");
    look(KB ^ KW'(16'hFFFF), 8'd5, "R3 don't-care low bits");
    put(1, KB, LOW16DC, 8'd5, 32'hCCCC_0001, "R7 install overlap");
    look(KB, 8'd5, "R5 lowest index wins");
    put(2, KB, FULL, 8'd9, 32'hDDDD_0002, "R7 install tenant 9");
    look(KB, 8'd9, "R4 same key tenant 9");
    look(KB, 8'd5, "R4 R5 tenant 5 unaffected");

    idle("R9 hold after hit");
    idle("R9 hold second idle");

    // Same-cycle collisions
    step(1, KB, 8'd5, 1, 1, 0, '0, '0, '0, '0, "R8 invalidate same cycle uses old");
    look(KB, 8'd5, "R7 invalidate visible next");
    step(1, KB, 8'd5, 1, 0, 1, KB, FULL, 8'd5, 32'hEEEE_0000, "R8 install same cycle uses old");
    look(KB, 8'd5, "R7 R5 new entry 0 wins");
    step(1, KA, 8'd5, 1, 3, 1, KA, FULL, 8'd5, 32'h1111_2222, "R8 overwrite same cycle");
    look(KA, 8'd5, "R7 overwrite visible");

    // Random mix against the behavioural table
    for (int n = 0; n < 400; n++) begin
      automatic logic [KW-1:0] k = {KA[KW-1:16], 16'($urandom % 4)};
      automatic logic [SW-1:0] s = SW'($urandom % 3);
      automatic bit we = ($urandom % 4) == 0;
      automatic bit wv = ($urandom % 3) != 0;
      automatic logic [KW-1:0] m = ($urandom % 2) ? FULL : {{(KW-1){1'b1}}, 1'b0};
      step(($urandom % 4) != 0, k, s, we, int'($urandom % N), wv,
           {KA[KW-1:16], 16'($urandom % 4)}, m, SW'($urandom % 3), $urandom,
           "R3 R4 R5 R7 R8 R9 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule